// File: doc/BRIEF.md
# Asynchronous Transmit Start Sequencer

This block sits in front of an asynchronous serial transmitter and decides when the first character may leave. It watches a "transmit queue holds data" flag and a one-cycle bit-time enable that marks each falling edge of the transmit clock. When data is waiting and a bit time arrives, it raises the request-to-send output. It then waits for clear-to-send and releases the first character, whose first bit is its start bit, with a one-cycle start pulse after a fixed number of bit times.

There are two latencies. If clear-to-send is already high on the bit time where request-to-send rises, two bit times follow before the start pulse. If clear-to-send arrives later, the latency depends on the sampling option. With the sampled option, clear-to-send is seen only on a bit time and three more bit times follow. With the immediate option, clear-to-send is seen on any clock cycle and two bit times follow. A countdown counter is brought out for debug. Request-to-send falls once the shifter reports the end of the last stop bit and the queue is empty. All pins are plain control signals. There is no data stream here, so there is no valid/ready handshake and no back-pressure.

Top module: `tx_start_seq`

## Requirements
- R1: After reset `rts` is 0, `tx_start` is 0 and `bit_cnt` is 0.
- R2: `rts` rises only on a cycle where `bit_tick` and `fifo_nonempty` are both 1. `bit_tick` with an empty queue has no effect, and neither has `fifo_nonempty` without `bit_tick`.
- R3: If `cts` is 1 on the bit time where `rts` rises, `tx_start` pulses right after the second following bit time. This holds in both sampling modes.
- R4: With `cts_immediate` = 0, if `cts` was 0 when `rts` rose, `cts` is seen only on a bit time where it is 1. `tx_start` pulses right after the third bit time following that one.
- R5: With `cts_immediate` = 1, if `cts` was 0 when `rts` rose, `cts` is seen on any clock cycle where it is 1. `tx_start` pulses right after the second bit time following.
- R6: If `cts` is 0 on a bit time during the countdown, the countdown is cleared and the block waits for `cts` again. On its return the latency of R4 or R5 applies.
- R7: `tx_start` lasts exactly one clock cycle. It occurs only while `rts` is 1, and only when `cts` was 1 on the bit time that ended the countdown.
- R8: `bit_cnt` gives the number of bit times counted since `cts` was seen. It is 0 while waiting, and it returns to 0 with the start pulse.
- R9: After the start, `rts` falls on the cycle after `char_done` = 1 with `fifo_nonempty` = 0. `char_done` while the queue still holds data leaves `rts` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle enable per falling transmit-clock edge |
| fifo_nonempty | input | 1 | Transmit queue holds at least one character |
| cts | input | 1 | Clear-to-send, 1 = asserted |
| cts_immediate | input | 1 | 1 = immediate CTS option, 0 = sampled option |
| char_done | input | 1 | Shifter finished the last stop bit of a character |
| rts | output | 1 | Request-to-send, 1 = asserted |
| tx_start | output | 1 | One-cycle pulse releasing the first character |
| bit_cnt | output | CNT_W | Countdown progress in bit times (debug) |

## Verification
The bench builds the block with its default latencies of 2 for ready-CTS, 3 for sampled and 2 for immediate. With these values the counter spans 0 to 2 and is 2 bits wide. The difference between the three-bit-time path and the two-bit-time paths can then be seen tick by tick. The bench also drops CTS partway through a countdown, enables CTS between ticks in immediate mode, and sends `char_done` both with data still queued and with the queue empty.

// File: rtl/tx_start_seq_pkg.sv
package tx_start_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_COUNT = 2'd2,
    ST_SEND  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/tx_seq_latsel.sv
module tx_seq_latsel #(
  parameter int LAT_READY = 2,
  parameter int LAT_SYNC  = 3,
  parameter int LAT_IMM   = 2,
  parameter int W         = 2
) (
  input  logic         cts_immediate,
  output logic [W-1:0] lat_ready,
  output logic [W-1:0] lat_late
);
  localparam logic [W-1:0] L_READY = W'(LAT_READY);
  localparam logic [W-1:0] L_SYNC  = W'(LAT_SYNC);
  localparam logic [W-1:0] L_IMM   = W'(LAT_IMM);

  // Latency is given as a count of bit times after the seen tick.
  assign lat_ready = L_READY;
  assign lat_late  = cts_immediate ? L_IMM : L_SYNC;
endmodule

// File: rtl/tx_seq_cnt.sv
module tx_seq_cnt #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/tx_seq_ctrl.sv
module tx_seq_ctrl
  import tx_start_seq_pkg::*;
#(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_tick,
  input  logic         fifo_nonempty,
  input  logic         cts,
  input  logic         cts_immediate,
  input  logic         char_done,
  input  logic [W-1:0] lat_ready,
  input  logic [W-1:0] lat_late,
  input  logic [W-1:0] cnt,
  output logic         cnt_clr,
  output logic         cnt_inc,
  output logic         rts,
  output logic         tx_start
);
  seq_state_e   state, state_n;
  logic [W-1:0] target, target_n;
  logic         rts_n, start_n, cts_seen;

  assign cts_seen = cts_immediate ? cts : (cts && bit_tick);

  always_comb begin
    state_n  = state;
    target_n = target;
    rts_n    = rts;
    start_n  = 1'b0;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    case (state)
      ST_IDLE: begin
        cnt_clr = 1'b1;
        if (bit_tick && fifo_nonempty) begin
          rts_n = 1'b1;
          if (cts) begin
            state_n  = ST_COUNT;
            target_n = lat_ready;
          end else begin
            state_n = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        cnt_clr = 1'b1;
        if (cts_seen) begin
          state_n  = ST_COUNT;
          target_n = lat_late;
        end
      end
      ST_COUNT: begin
        if (bit_tick) begin
          if (!cts) begin
            state_n = ST_WAIT;
            cnt_clr = 1'b1;
          end else if (cnt == target - W'(1)) begin
            start_n = 1'b1;
            state_n = ST_SEND;
            cnt_clr = 1'b1;
          end else begin
            cnt_inc = 1'b1;
          end
        end
      end
      ST_SEND: begin
        cnt_clr = 1'b1;
        if (char_done && !fifo_nonempty) begin
          rts_n   = 1'b0;
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      target   <= '0;
      rts      <= 1'b0;
      tx_start <= 1'b0;
    end else begin
      state    <= state_n;
      target   <= target_n;
      rts      <= rts_n;
      tx_start <= start_n;
    end
  end
endmodule

// File: rtl/tx_start_seq.sv
module tx_start_seq #(
  parameter int LAT_READY = 2,
  parameter int LAT_SYNC  = 3,
  parameter int LAT_IMM   = 2,
  parameter int LAT_MAX   = (LAT_READY > LAT_SYNC)
                            ? ((LAT_READY > LAT_IMM) ? LAT_READY : LAT_IMM)
                            : ((LAT_SYNC > LAT_IMM) ? LAT_SYNC : LAT_IMM),
  parameter int CNT_W     = $clog2(LAT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             fifo_nonempty,
  input  logic             cts,
  input  logic             cts_immediate,
  input  logic             char_done,
  output logic             rts,
  output logic             tx_start,
  output logic [CNT_W-1:0] bit_cnt
);
  logic [CNT_W-1:0] lat_ready, lat_late;
  logic             cnt_clr, cnt_inc;

  tx_seq_latsel #(
    .LAT_READY(LAT_READY), .LAT_SYNC(LAT_SYNC), .LAT_IMM(LAT_IMM), .W(CNT_W)
  ) u_latsel (
    .cts_immediate(cts_immediate),
    .lat_ready    (lat_ready),
    .lat_late     (lat_late)
  );

  tx_seq_cnt #(.W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (cnt_clr),
    .inc  (cnt_inc),
    .cnt  (bit_cnt)
  );

  tx_seq_ctrl #(.W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_tick     (bit_tick),
    .fifo_nonempty(fifo_nonempty),
    .cts          (cts),
    .cts_immediate(cts_immediate),
    .char_done    (char_done),
    .lat_ready    (lat_ready),
    .lat_late     (lat_late),
    .cnt          (bit_cnt),
    .cnt_clr      (cnt_clr),
    .cnt_inc      (cnt_inc),
    .rts          (rts),
    .tx_start     (tx_start)
  );
endmodule

// File: rtl/tx_start_seq_chk.sv
module tx_start_seq_chk #(
  parameter int LAT_MAX = 3,
  parameter int CNT_W   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_tick,
  input logic             fifo_nonempty,
  input logic             cts,
  input logic             char_done,
  input logic             rts,
  input logic             tx_start,
  input logic [CNT_W-1:0] bit_cnt
);
  p_rts_rise_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts) |-> $past(bit_tick && fifo_nonempty));

  p_start_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  p_start_needs_cts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (rts && $past(cts && bit_tick)));

  p_rts_fall_when_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts) |-> $past(char_done && !fifo_nonempty));

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(bit_cnt) < LAT_MAX);

  p_cnt_zero_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rts |-> (bit_cnt == '0));
endmodule

bind tx_start_seq tx_start_seq_chk #(.LAT_MAX(LAT_MAX), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .fifo_nonempty(fifo_nonempty),
  .cts(cts), .char_done(char_done), .rts(rts), .tx_start(tx_start), .bit_cnt(bit_cnt)
);

// File: tb/test_tx_start_seq.sv
`timescale 1ns/1ps
module test_tx_start_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0, fifo_nonempty = 1'b0, cts = 1'b0;
  logic       cts_immediate = 1'b0, char_done = 1'b0;
  logic       rts, tx_start;
  logic [1:0] bit_cnt;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  tx_start_seq i_tx_start_seq (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .fifo_nonempty(fifo_nonempty),
    .cts(cts), .cts_immediate(cts_immediate), .char_done(char_done),
    .rts(rts), .tx_start(tx_start), .bit_cnt(bit_cnt)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_clk();
    @(negedge clk);
  endtask

  task automatic do_tick();
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
  endtask

  task automatic pulse_done(logic more);
    fifo_nonempty = more;
    char_done = 1'b1;
    @(negedge clk);
    char_done = 1'b0;
  endtask

  task automatic finish_frame(string req);
    pulse_done(1'b1);
    chk({req, " rts held, data queued"}, rts, 1);
    pulse_done(1'b0);
    chk({req, " rts dropped, queue empty"}, rts, 0);
    idle_clk();
  endtask

  task automatic t_reset();
    chk("R1 rts", rts, 0);
    chk("R1 tx_start", tx_start, 0);
    chk("R1 bit_cnt", bit_cnt, 0);
  endtask

  task automatic t_ignore();
    fifo_nonempty = 1'b0; cts = 1'b1;
    do_tick(); do_tick();
    chk("R2 tick, empty queue", rts, 0);
    fifo_nonempty = 1'b1;
    repeat (3) idle_clk();
    chk("R2 data, no tick", rts, 0);
    do_tick();
    chk("R2 rts rises", rts, 1);
    fifo_nonempty = 1'b0;
    do_tick(); do_tick();
    chk("R2 start after ready path", tx_start, 1);
    finish_frame("R9");
  endtask

  task automatic t_ready(logic imm);
    cts_immediate = imm; cts = 1'b1; fifo_nonempty = 1'b1;
    do_tick();
    chk("R3 rts", rts, 1);
    chk("R3 no start at rise", tx_start, 0);
    do_tick();
    chk("R8 cnt after 1 tick", bit_cnt, 1);
    chk("R3 no start after 1", tx_start, 0);
    do_tick();
    chk("R3 start after 2", tx_start, 1);
    chk("R8 cnt cleared", bit_cnt, 0);
    idle_clk();
    chk("R7 pulse one cycle", tx_start, 0);
    finish_frame("R9");
  endtask

  task automatic t_sync_late();
    cts_immediate = 1'b0; cts = 1'b0; fifo_nonempty = 1'b1;
    do_tick();
    chk("R4 rts", rts, 1);
    do_tick(); do_tick();
    chk("R4 waiting", tx_start, 0);
    chk("R8 cnt zero waiting", bit_cnt, 0);
    cts = 1'b1;
    repeat (2) idle_clk();
    chk("R4 no sample off tick", bit_cnt, 0);
    do_tick();
    chk("R4 seen tick", bit_cnt, 0);
    do_tick();
    chk("R4 after 1", bit_cnt, 1);
    do_tick();
    chk("R4 after 2 cnt", bit_cnt, 2);
    chk("R4 no start after 2", tx_start, 0);
    do_tick();
    chk("R4 start after 3", tx_start, 1);
    finish_frame("R9");
  endtask

  task automatic t_imm_late();
    cts_immediate = 1'b1; cts = 1'b0; fifo_nonempty = 1'b1;
    do_tick();
    chk("R5 rts", rts, 1);
    cts = 1'b1;
    idle_clk();
    do_tick();
    chk("R5 after 1", bit_cnt, 1);
    chk("R5 no start after 1", tx_start, 0);
    do_tick();
    chk("R5 start after 2", tx_start, 1);
    finish_frame("R9");
  endtask

  task automatic t_drop();
    cts_immediate = 1'b0; cts = 1'b1; fifo_nonempty = 1'b1;
    do_tick();
    do_tick();
    chk("R6 counting", bit_cnt, 1);
    cts = 1'b0;
    do_tick();
    chk("R6 cleared on drop", bit_cnt, 0);
    chk("R6 no start on drop", tx_start, 0);
    do_tick();
    chk("R6 still waiting", tx_start, 0);
    chk("R6 rts held", rts, 1);
    cts = 1'b1;
    do_tick();
    do_tick(); do_tick();
    chk("R6 no start after 2 on return", tx_start, 0);
    do_tick();
    chk("R6 start after 3 on return", tx_start, 1);
    finish_frame("R9");
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle_clk();
    t_reset();
    t_ignore();
    t_ready(1'b0);
    t_ready(1'b1);
    t_sync_late();
    t_imm_late();
    t_drop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule